// File: doc/BRIEF.md
# Radix-8 Booth Integer Multiplier Core

This block multiplies two unsigned integers of `W` bits each (8 by default) and returns the full `2W`-bit product. The multiplier operand is recoded into signed radix-8 digits, each ranging from -4 to +4. Every digit selects one multiple of the multiplicand Y: 0, Y, 2Y, 3Y or 4Y. A negative digit inverts the multiple it selects. The only multiple that is not a plain shift is 3Y. A small bit-serial ripple adder forms it as Y + 2Y, one bit per clock cycle, which takes the place of a wide fast adder.

The selected rows feed a tree of 3:2 carry-save layers. Every row is sign-extended to the full product width. The +1 corrections of the negative rows are collected into one extra row. Once the tree has reduced the rows to a sum and a carry vector, one carry-propagate add yields the product.

Operands enter through a valid/ready handshake. A transfer takes place on a clock edge where `in_valid` and `in_ready` are both high. The result arrives a fixed number of cycles later, marked by a one-cycle `out_valid` pulse. The product then stays on `out_product` until the next result replaces it.

Top module: `radix8_mult`

## Requirements
- R1: While `rst_n` is low, and after it is released with no transfer yet made, `in_ready` is 1, `out_valid` is 0 and `out_product` is 0.
- R2: A transfer takes place on a rising edge where `in_valid` and `in_ready` are both 1. From the next cycle, `in_ready` stays 0 until the result of that transfer is presented.
- R3: `out_valid` goes to 1 exactly W+2 rising edges after the transfer edge, which is 10 edges for W=8. It stays 1 for that single cycle and is 0 in every cycle in between.
- R4: When `out_valid` is 1, `out_product` equals the exact unsigned product `in_a * in_b` of the transferred operands, `in_a` being the multiplicand and `in_b` the multiplier. This holds for every operand pair.
- R5: Any values on `in_valid`, `in_a` and `in_b` while `in_ready` is 0 are ignored. They change neither the pending result nor its timing.
- R6: Between two results, `out_product` holds its last value and `out_valid` stays 0.
- R7: The multiplier is read in groups of three bits plus the top bit of the group below it. Group g covers bits 3g+2 down to 3g-1, and bit -1 reads as 0. Each group forms the digit -4·b(3g+2) + 2·b(3g+1) + b(3g) + b(3g-1). Multipliers 1 to 7 in the lowest group produce the digits +1, +2, +3, -4, -3, -2 and -1, each with its carry into the next group, and all of them give exact products.
- R8: Boundary operands give exact products. These are zero in either operand, one, and the all-ones multiplicand, which makes the longest carry chain in 3Y. With all-ones in both operands the product is (2^W-1)^2.
- R9: `in_ready` returns to 1 in the same cycle that `out_valid` is 1. An operand pair offered in that cycle is accepted at the next edge, back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block is idle and can take an operand pair |
| in_a | input | W | Multiplicand Y (unsigned) |
| in_b | input | W | Multiplier (unsigned), recoded into radix-8 digits |
| out_valid | output | 1 | One-cycle pulse when a new product is presented |
| out_product | output | 2W | Product of the last transferred pair, held between results |

## Verification
The assertions assume that operand values only matter on an accepting edge. They also assume that `out_valid` can come only from an earlier transfer, so the latency counter in the checker starts at the accepting edge. The bench changes inputs only 1 ns after a rising edge. It offers a new pair only in cycles where it expects `in_ready` to be 1, except in the scenario that deliberately holds junk on the inputs while the block is busy. The product checks cover every multiplicand against the lowest sixteen multipliers, a pseudo-random sweep and the digit and carry-chain corner values.

// File: rtl/r8m_pkg.sv
package r8m_pkg;

   // One signed radix-8 digit: sign and magnitude 0..4
   typedef struct packed {
      logic       neg;
      logic [2:0] mag;
   } r8_digit_t;

   // Digit groups needed for an unsigned W-bit multiplier (one extra zero bit on top)
   function automatic int unsigned num_groups(input int unsigned w);
      return (w + 3) / 3;
   endfunction

   // Rows left after one 3:2 layer
   function automatic int unsigned csa_next(input int unsigned n);
      return 2 * (n / 3) + (n % 3);
   endfunction

   // Row count entering layer lvl
   function automatic int unsigned csa_rows_at(input int unsigned n, input int unsigned lvl);
      int unsigned c;
      c = n;
      for (int unsigned i = 0; i < lvl; i++) c = csa_next(c);
      return c;
   endfunction

   // Layers until two rows remain
   function automatic int unsigned csa_levels(input int unsigned n);
      int unsigned c;
      int unsigned l;
      c = n;
      l = 0;
      while (c > 2) begin
         c = csa_next(c);
         l++;
      end
      return l;
   endfunction

   // g = {b(3i+2), b(3i+1), b(3i), b(3i-1)}
   function automatic r8_digit_t recode(input logic [3:0] g);
      int        v;
      r8_digit_t d;
      v = 2 * int'(g[2]) + int'(g[1]) + int'(g[0]) - 4 * int'(g[3]);
      d.neg = (v < 0);
      d.mag = 3'((v < 0) ? -v : v);
      return d;
   endfunction

endpackage

// File: rtl/r8m_recode.sv
module r8m_recode
   import r8m_pkg::*;
#(
   parameter int unsigned W = 8,
   parameter int unsigned G = num_groups(W)
) (
   input  logic [W-1:0]          mult_i,
   output r8_digit_t [G-1:0]     digits_o
);

   localparam int unsigned XW  = 3 * G + 1;
   localparam int unsigned PAD = XW - W - 1;

   // bit 0 stands for the implicit zero below the LSB
   logic [XW-1:0] ext;
   assign ext = {{PAD{1'b0}}, mult_i, 1'b0};

   for (genvar g = 0; g < G; g++) begin : g_grp
      assign digits_o[g] = recode(ext[3*g+3 : 3*g]);
   end

endmodule

// File: rtl/r8m_ripple3y.sv
module r8m_ripple3y #(
   parameter int unsigned W = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start_i,
   input  logic [W-1:0]   y_i,
   output logic [W+1:0]   y3_o,
   output logic           done_o
);

   localparam int unsigned SW = W + 2;
   localparam int unsigned IW = $clog2(SW + 1);

   logic [SW-1:0] y_q;
   logic [SW-1:0] acc_q;
   logic          carry_q;
   logic [IW-1:0] idx_q;
   logic          run_q;
   logic          done_q;

   logic bit_y, bit_2y, sum_b, carry_b;

   always_comb begin
      bit_y   = y_q[idx_q];
      bit_2y  = y_q[idx_q - IW'(1)];
      sum_b   = bit_y ^ bit_2y ^ carry_q;
      carry_b = (bit_y & bit_2y) | (bit_y & carry_q) | (bit_2y & carry_q);
   end

   // Bit 0 of 3Y equals y[0]; bits 1..W+1 follow one per cycle
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         y_q     <= '0;
         acc_q   <= '0;
         carry_q <= 1'b0;
         idx_q   <= '0;
         run_q   <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start_i) begin
            y_q     <= {2'b00, y_i};
            acc_q   <= {{(SW-1){1'b0}}, y_i[0]};
            carry_q <= 1'b0;
            idx_q   <= IW'(1);
            run_q   <= 1'b1;
         end else if (run_q) begin
            acc_q[idx_q] <= sum_b;
            carry_q      <= carry_b;
            if (idx_q == IW'(SW - 1)) begin
               run_q  <= 1'b0;
               done_q <= 1'b1;
            end else begin
               idx_q <= idx_q + IW'(1);
            end
         end
      end
   end

   assign y3_o   = acc_q;
   assign done_o = done_q;

endmodule

// File: rtl/r8m_ppgen.sv
module r8m_ppgen
   import r8m_pkg::*;
#(
   parameter int unsigned W  = 8,
   parameter int unsigned G  = num_groups(W),
   parameter int unsigned PW = 2 * W
) (
   input  logic [W-1:0]           y_i,
   input  logic [W+1:0]           y3_i,
   input  r8_digit_t [G-1:0]      digits_i,
   output logic [G:0][PW-1:0]     rows_o
);

   localparam int unsigned MW = W + 2;

   logic [MW-1:0] m1, m2, m4;
   assign m1 = {2'b00, y_i};
   assign m2 = {1'b0, y_i, 1'b0};
   assign m4 = {y_i, 2'b00};

   for (genvar g = 0; g < G; g++) begin : g_row
      logic [MW-1:0] sel;
      logic [PW-1:0] ext;
      always_comb begin
         case (digits_i[g].mag)
            3'd1:    sel = m1;
            3'd2:    sel = m2;
            3'd3:    sel = y3_i;
            3'd4:    sel = m4;
            default: sel = '0;
         endcase
      end
      // inversion of the zero-extended multiple is its full-width sign extension
      assign ext       = PW'(sel);
      assign rows_o[g] = (digits_i[g].neg ? ~ext : ext) << (3 * g);
   end

   // +1 corrections of negative rows gathered in one row
   always_comb begin
      rows_o[G] = '0;
      for (int g = 0; g < G; g++) rows_o[G][3*g] = digits_i[g].neg;
   end

endmodule

// File: rtl/r8m_csa_tree.sv
module r8m_csa_tree
   import r8m_pkg::*;
#(
   parameter int unsigned PW = 16,
   parameter int unsigned NR = 4
) (
   input  logic [NR-1:0][PW-1:0] rows_i,
   output logic [PW-1:0]         sum_o,
   output logic [PW-1:0]         carry_o
);

   localparam int unsigned NL = csa_levels(NR);

   if (NR < 3) begin : g_bad_rows
      $error("r8m_csa_tree needs at least three rows");
   end

   for (genvar l = 0; l < NL; l++) begin : g_lvl
      localparam int unsigned N  = csa_rows_at(NR, l);
      localparam int unsigned NN = csa_next(N);
      localparam int unsigned T  = N / 3;
      localparam int unsigned RM = N % 3;

      logic [PW-1:0] cur [N];
      logic [PW-1:0] nxt [NN];

      if (l == 0) begin : g_src_in
         for (genvar r = 0; r < N; r++) begin : g_r
            assign cur[r] = rows_i[r];
         end
      end else begin : g_src_lvl
         for (genvar r = 0; r < N; r++) begin : g_r
            assign cur[r] = g_lvl[l-1].nxt[r];
         end
      end

      for (genvar t = 0; t < T; t++) begin : g_fa
         assign nxt[2*t]   = cur[3*t] ^ cur[3*t+1] ^ cur[3*t+2];
         assign nxt[2*t+1] = ((cur[3*t] & cur[3*t+1]) |
                              (cur[3*t] & cur[3*t+2]) |
                              (cur[3*t+1] & cur[3*t+2])) << 1;
      end

      for (genvar k = 0; k < RM; k++) begin : g_pass
         assign nxt[2*T+k] = cur[3*T+k];
      end
   end

   assign sum_o   = g_lvl[NL-1].nxt[0];
   assign carry_o = g_lvl[NL-1].nxt[1];

endmodule

// File: rtl/radix8_mult.sv
module radix8_mult
   import r8m_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [W-1:0]      in_a,
   input  logic [W-1:0]      in_b,
   output logic              out_valid,
   output logic [2*W-1:0]    out_product
);

   localparam int unsigned G  = num_groups(W);
   localparam int unsigned PW = 2 * W;
   localparam int unsigned NR = G + 1;

   if (W < 4) begin : g_bad_width
      $error("radix8_mult needs W >= 4");
   end

   logic              busy_q;
   logic [W-1:0]      a_q;
   logic [W-1:0]      b_q;
   logic              vld_q;
   logic [PW-1:0]     prod_q;

   logic              accept;
   logic [W+1:0]      y3;
   logic              y3_done;
   r8_digit_t [G-1:0] digits;
   logic [NR-1:0][PW-1:0] rows;
   logic [PW-1:0]     csa_s;
   logic [PW-1:0]     csa_c;
   logic [PW-1:0]     prod_d;

   assign accept = in_valid & ~busy_q;

   r8m_ripple3y #(.W(W)) u_3y (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (accept),
      .y_i     (in_a),
      .y3_o    (y3),
      .done_o  (y3_done)
   );

   r8m_recode #(.W(W), .G(G)) u_rec (
      .mult_i   (b_q),
      .digits_o (digits)
   );

   r8m_ppgen #(.W(W), .G(G), .PW(PW)) u_pp (
      .y_i      (a_q),
      .y3_i     (y3),
      .digits_i (digits),
      .rows_o   (rows)
   );

   r8m_csa_tree #(.PW(PW), .NR(NR)) u_tree (
      .rows_i  (rows),
      .sum_o   (csa_s),
      .carry_o (csa_c)
   );

   assign prod_d = csa_s + csa_c;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         a_q    <= '0;
         b_q    <= '0;
         vld_q  <= 1'b0;
         prod_q <= '0;
      end else begin
         vld_q <= 1'b0;
         if (accept) begin
            busy_q <= 1'b1;
            a_q    <= in_a;
            b_q    <= in_b;
         end else if (y3_done) begin
            busy_q <= 1'b0;
            vld_q  <= 1'b1;
            prod_q <= prod_d;
         end
      end
   end

   assign in_ready    = ~busy_q;
   assign out_valid   = vld_q;
   assign out_product = prod_q;

endmodule

// File: rtl/r8m_checker.sv
module r8m_checker #(
   parameter int unsigned W = 8
) (
   input logic           clk,
   input logic           rst_n,
   input logic           in_valid,
   input logic           in_ready,
   input logic [W-1:0]   in_a,
   input logic [W-1:0]   in_b,
   input logic           out_valid,
   input logic [2*W-1:0] out_product
);

   localparam int unsigned PW  = 2 * W;
   localparam int unsigned LAT = W + 2;
   localparam int unsigned CW  = $clog2(LAT + 2) + 1;

   logic [CW-1:0] cnt_q;
   logic [W-1:0]  ref_a_q;
   logic [W-1:0]  ref_b_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         ref_a_q <= '0;
         ref_b_q <= '0;
      end else if (in_valid && in_ready) begin
         cnt_q   <= CW'(1);
         ref_a_q <= in_a;
         ref_b_q <= in_b;
      end else if (cnt_q == CW'(LAT + 1)) begin
         cnt_q <= '0;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

   AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready); // R2

   AST_VALID_ONLY_WHEN_DUE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (cnt_q == CW'(LAT + 1))); // R3

   AST_VALID_WHEN_DUE: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CW'(LAT + 1)) |-> out_valid); // R3

   AST_PRODUCT_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_product == PW'(ref_a_q) * PW'(ref_b_q))); // R4

   AST_PRODUCT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_product)); // R6

   AST_READY_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> in_ready); // R9

endmodule

bind radix8_mult r8m_checker #(.W(W)) u_chk (.*);

// File: tb/radix8_mult_tb.sv
module radix8_mult_tb;

   localparam int unsigned W   = 8;
   localparam int unsigned PW  = 2 * W;
   localparam int unsigned LAT = W + 2;
   localparam int unsigned WD  = 190000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [W-1:0]  in_a = '0;
   logic [W-1:0]  in_b = '0;
   logic          out_valid;
   logic [PW-1:0] out_product;

   int n_total = 0;
   int n_fail  = 0;

   always #2 clk = ~clk;

   radix8_mult #(.W(W)) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_ready    (in_ready),
      .in_a        (in_a),
      .in_b        (in_b),
      .out_valid   (out_valid),
      .out_product (out_product)
   );

   task automatic check(input logic ok, input string req,
                        input logic [PW-1:0] act, input logic [PW-1:0] exp_v);
      n_total++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
      end
   endtask

   // One operation from a cycle with in_ready high; returns 1 ns after the result edge
   task automatic do_op(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
      logic          ok_t;
      logic [PW-1:0] exp_p;
      exp_p    = PW'(a) * PW'(b);
      ok_t     = 1'b1;
      in_a     = a;
      in_b     = b;
      in_valid = 1'b1;
      @(posedge clk); #1;
      in_valid = 1'b0;
      if (in_ready || out_valid) ok_t = 1'b0;
      for (int k = 1; k <= LAT; k++) begin
         @(posedge clk); #1;
         if (k < LAT && (out_valid || in_ready)) ok_t = 1'b0;
      end
      // R2 R3 R9: busy window, single pulse at W+2 edges, ready back with result
      check(ok_t && out_valid && in_ready, "R3", PW'(out_valid), PW'(1));
      check(out_product == exp_p, req, out_product, exp_p);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      check(in_ready && !out_valid && out_product == '0, "R1",
            out_product, '0);
      rst_n = 1'b1;
      repeat (2) @(posedge clk);
      #1;
      check(in_ready && !out_valid && out_product == '0, "R1",
            PW'({in_ready, out_valid}), PW'(2));
   endtask

   task automatic t_digits();
      for (int b = 1; b < 8; b++) begin
         do_op(8'hA7, W'(b), "R7");
         do_op(8'hFF, W'(b), "R7");
      end
      do_op(8'h5B, 8'b1011_0110, "R7");
      do_op(8'h3C, 8'b1101_1101, "R7");
   endtask

   task automatic t_corners();
      do_op('0, '0, "R8");
      do_op('1, '0, "R8");
      do_op('0, '1, "R8");
      do_op(W'(1), '1, "R8");
      do_op('1, W'(1), "R8");
      do_op('1, W'(3), "R8");
      do_op('1, '1, "R8");
   endtask

   task automatic t_sweep();
      for (int b = 0; b < 16; b++)
         for (int a = 0; a < (1 << W); a++)
            do_op(W'(a), W'(b), "R4");
   endtask

   task automatic t_random();
      logic [15:0] lf;
      lf = 16'hACE1;
      for (int i = 0; i < 2000; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         do_op(lf[W-1:0], lf[15:16-W] ^ W'(i), "R4");
      end
   endtask

   task automatic t_busy_ignore();
      logic ok_t;
      ok_t     = 1'b1;
      in_a     = 8'd201;
      in_b     = 8'd77;
      in_valid = 1'b1;
      @(posedge clk); #1;
      in_a = 8'd13;
      in_b = 8'd250;
      for (int k = 1; k <= LAT; k++) begin
         @(posedge clk); #1;
         if (k < LAT && (in_ready || out_valid)) ok_t = 1'b0;
      end
      check(ok_t && out_valid, "R5", PW'(out_valid), PW'(1));
      check(out_product == PW'(201 * 77), "R5", out_product, PW'(201 * 77));
      // in_valid still high in the result cycle: accepted back to back
      for (int k = 1; k <= LAT + 1; k++) begin
         @(posedge clk); #1;
         if (k == 1) begin
            if (in_ready) ok_t = 1'b0;
            in_valid = 1'b0;
         end
      end
      check(ok_t && out_valid, "R9", PW'(out_valid), PW'(1));
      check(out_product == PW'(13 * 250), "R9", out_product, PW'(13 * 250));
   endtask

   task automatic t_hold();
      logic ok_t;
      ok_t = 1'b1;
      do_op(8'd99, 8'd45, "R4");
      for (int k = 0; k < 6; k++) begin
         @(posedge clk); #1;
         if (out_valid || out_product != PW'(99 * 45)) ok_t = 1'b0;
      end
      check(ok_t, "R6", out_product, PW'(99 * 45));
   endtask

   initial begin
      repeat (WD) @(posedge clk);
      n_total++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

   initial begin
      t_reset();
      t_digits();
      t_corners();
      t_busy_ignore();
      @(posedge clk); #1;
      t_hold();
      t_sweep();
      t_random();
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

endmodule